// File: doc/BRIEF.md
# Programmable-Length SPI Transmit Character Serializer

This block accepts one transmit character at a time as a 16-bit parallel word and drives it onto a serial data line, one bit for each shift strobe. A 4-bit length code sets the character size. The code plus one gives the number of bits. Codes below 3 are raised to a 4-bit character. Only the low bits of the word that belong to the character are used. The rest of the word is ignored.

The bit order is chosen per character. With reversal off, the character leaves least significant bit first. For characters longer than 8 bits, this means the low byte goes first. With reversal on, the character is mirrored before shifting, so its most significant bit appears first on the line. A ready/valid handshake accepts a new character only while the line is idle. A one-cycle completion pulse marks the end of each character.

A small event register records two events: a character was taken, and a character finished. Each bit is cleared by writing 1 to it. A mask register enables each bit onto a single interrupt output. Bit-rate clock generation, chip selects and reception belong to neighbouring blocks.

Top module: `spi_char_serializer`

## Requirements
- R1: The character size is max(len_code, 3) + 1 bits. Exactly that many shift strobes taken while busy complete the character, and the handshake stays busy until the last of them.
- R2: With reverse off, the k-th bit on the line is data bit k (k = 0 is presented right after the load and advances on each accepted shift strobe). Data bits at or above the size never reach the line.
- R3: With reverse on, the k-th bit on the line is data bit size-1-k, so the character's most significant bit leaves first.
- R4: `ld_ready` is high while idle. It is low from the edge that accepts a load until the edge that takes the last bit. A load offered while `ld_ready` is low is ignored and leaves the current character and the line untouched.
- R5: `char_done` is high for exactly one cycle, in the cycle after the edge that takes the last bit. While idle, `shift_en` is ignored: `sdo` stays 0 and no completion or event occurs.
- R6: Event bit 0 (done) sets at the edge that takes the last bit. Event bit 1 (load) sets at the edge that accepts a load. Set bits stay set until cleared.
- R7: Writing with `evt_clr_we` clears, at the next edge, every event bit whose `evt_clr_bits` bit is 1. Bits written with 0 keep their value.
- R8: If an event sets a bit in the same cycle that a clear write hits that bit, the bit ends up set.
- R9: `mask_we` loads `mask_bits` into the mask register. `irq` is high exactly when some event bit and its mask bit are both 1.
- R10: After reset, `ld_ready`=1, `sdo`=0, `char_done`=0, events=0, mask=0 and `irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_valid | input | 1 | A character is offered on the load port |
| ld_ready | output | 1 | Serializer idle, load will be taken |
| ld_data | input | 16 | Character data, taken from the low bits |
| ld_len | input | 4 | Length code, size = max(code,3)+1 |
| ld_rev | input | 1 | 1 = mirrored order, MSB first |
| shift_en | input | 1 | Advance one bit on the line |
| sdo | output | 1 | Serial data bit |
| char_done | output | 1 | One-cycle completion pulse |
| evt_clr_we | input | 1 | Write strobe for event clear |
| evt_clr_bits | input | 2 | Write-1-to-clear pattern |
| mask_we | input | 1 | Mask register write strobe |
| mask_bits | input | 2 | New mask value |
| evt_bits | output | 2 | Event register: bit0 done, bit1 load |
| mask_q | output | 2 | Mask register |
| irq | output | 1 | Masked OR of event bits |

## Verification
The first line bit is valid one cycle after the accepting edge. Each later bit is valid one cycle after the edge that took its strobe. The completion pulse, the raised `ld_ready` and the done event all appear together in the cycle after the last strobe. Event clears and mask writes take effect after one edge, and `irq` follows them in the same cycle. The bench drives every input on the falling edge and samples on the next falling edge. This places each reading exactly one register stage after its stimulus, and the cycle after a completion is checked again to prove the pulse has dropped.

// File: rtl/spi_ser_pkg.sv
package spi_ser_pkg;
  localparam int NUM_EVT = 2;
  typedef enum int {EV_DONE = 0, EV_LOAD = 1} evt_idx_e;
endpackage

// File: rtl/ser_rst_sync.sv
module ser_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/ser_bitorder.sv
// Builds the line-order vector: bit k of line_vec is the k-th bit sent.
module ser_bitorder #(
  parameter int DATA_W  = 16,
  parameter int LEN_W   = 4,
  parameter int MIN_LEN = 3
) (
  input  logic [DATA_W-1:0]             data,
  input  logic [LEN_W-1:0]              len,
  input  logic                          rev,
  output logic [DATA_W-1:0]             line_vec,
  output logic [$clog2(DATA_W+1)-1:0]   size
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int IDX_W = $clog2(DATA_W);

  logic [IDX_W-1:0] idx;

  always_comb begin
    if (int'(len) < MIN_LEN) size = CNT_W'(MIN_LEN + 1);
    else                     size = CNT_W'(int'(len) + 1);
    line_vec = '0;
    idx      = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(size)) begin
        // mirrored order picks from the character's top downward
        idx         = rev ? IDX_W'(int'(size) - 1 - i) : IDX_W'(i);
        line_vec[i] = data[idx];
      end
    end
  end
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
  parameter int DATA_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ld_valid,
  input  logic [DATA_W-1:0]               load_vec,
  input  logic [$clog2(DATA_W+1)-1:0]     load_size,
  input  logic                            shift_en,
  output logic                            ld_ready,
  output logic                            accept,
  output logic                            last_step,
  output logic                            sdo,
  output logic                            char_done
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic              busy_q, busy_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DATA_W-1:0] sr_q, sr_n;
  logic              done_q, done_n;
  logic              step;

  always_comb begin
    accept    = ld_valid & ~busy_q;
    step      = shift_en & busy_q;
    last_step = step & (cnt_q == CNT_W'(1));
    busy_n    = busy_q;
    cnt_n     = cnt_q;
    sr_n      = sr_q;
    done_n    = last_step;
    if (accept) begin
      busy_n = 1'b1;
      cnt_n  = load_size;
      sr_n   = load_vec;
    end else if (step) begin
      busy_n = ~last_step;
      cnt_n  = cnt_q - CNT_W'(1);
      sr_n   = {1'b0, sr_q[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sr_q   <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      sr_q   <= sr_n;
      done_q <= done_n;
    end
  end

  assign ld_ready  = ~busy_q;
  assign sdo       = sr_q[0] & busy_q;
  assign char_done = done_q;
endmodule

// File: rtl/ser_event_regs.sv
module ser_event_regs #(
  parameter int NUM_EVT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] set_bits,
  input  logic               clr_we,
  input  logic [NUM_EVT-1:0] clr_bits,
  input  logic               mask_we,
  input  logic [NUM_EVT-1:0] mask_bits,
  output logic [NUM_EVT-1:0] evt_q,
  output logic [NUM_EVT-1:0] mask_q,
  output logic               irq
);
  logic [NUM_EVT-1:0] mask_n;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    logic evt_n;
    always_comb begin
      // a new event outranks a same-cycle clear
      evt_n = set_bits[g] | (evt_q[g] & ~(clr_we & clr_bits[g]));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q[g] <= 1'b0;
      else        evt_q[g] <= evt_n;
    end
  end

  always_comb begin
    mask_n = mask_q;
    if (mask_we) mask_n = mask_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_n;
  end

  assign irq = |(evt_q & mask_q);
endmodule

// File: rtl/spi_char_serializer.sv
module spi_char_serializer
  import spi_ser_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int LEN_W   = 4,
  parameter int MIN_LEN = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_valid,
  output logic               ld_ready,
  input  logic [DATA_W-1:0]  ld_data,
  input  logic [LEN_W-1:0]   ld_len,
  input  logic               ld_rev,
  input  logic               shift_en,
  output logic               sdo,
  output logic               char_done,
  input  logic               evt_clr_we,
  input  logic [NUM_EVT-1:0] evt_clr_bits,
  input  logic               mask_we,
  input  logic [NUM_EVT-1:0] mask_bits,
  output logic [NUM_EVT-1:0] evt_bits,
  output logic [NUM_EVT-1:0] mask_q,
  output logic               irq
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic               rst_sync_n;
  logic [DATA_W-1:0]  line_vec;
  logic [CNT_W-1:0]   size;
  logic               accept;
  logic               last_step;
  logic [NUM_EVT-1:0] evt_set;

  ser_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ser_bitorder #(.DATA_W(DATA_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_order (
    .data     (ld_data),
    .len      (ld_len),
    .rev      (ld_rev),
    .line_vec (line_vec),
    .size     (size)
  );

  ser_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ld_valid  (ld_valid),
    .load_vec  (line_vec),
    .load_size (size),
    .shift_en  (shift_en),
    .ld_ready  (ld_ready),
    .accept    (accept),
    .last_step (last_step),
    .sdo       (sdo),
    .char_done (char_done)
  );

  always_comb begin
    evt_set          = '0;
    evt_set[EV_DONE] = last_step;
    evt_set[EV_LOAD] = accept;
  end

  ser_event_regs #(.NUM_EVT(NUM_EVT)) u_evt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .set_bits  (evt_set),
    .clr_we    (evt_clr_we),
    .clr_bits  (evt_clr_bits),
    .mask_we   (mask_we),
    .mask_bits (mask_bits),
    .evt_q     (evt_bits),
    .mask_q    (mask_q),
    .irq       (irq)
  );
endmodule

// File: rtl/spi_ser_checker.sv
module spi_ser_checker
  import spi_ser_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MIN_LEN = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ld_valid,
  input logic               ld_ready,
  input logic               shift_en,
  input logic               char_done,
  input logic               evt_clr_we,
  input logic [NUM_EVT-1:0] evt_clr_bits,
  input logic               mask_we,
  input logic [NUM_EVT-1:0] mask_bits,
  input logic [NUM_EVT-1:0] evt_bits,
  input logic               irq
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0] shifts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     shifts_q <= '0;
    else if (ld_valid && ld_ready)  shifts_q <= '0;
    else if (shift_en && !ld_ready) shifts_q <= shifts_q + CNT_W'(1);
  end

  // R1: completion only after a legal number of strobes
  a_r1_size_window: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |-> (int'(shifts_q) >= MIN_LEN + 1 && int'(shifts_q) <= DATA_W));
  a_r4_busy_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> !ld_ready);
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> !char_done);
  a_r5_idle_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready |=> !char_done);
  a_r4_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |-> ld_ready);
  a_r6_done_event: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |-> evt_bits[EV_DONE]);
  a_r7_clear_load_evt: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clr_we && evt_clr_bits[EV_LOAD] && !(ld_valid && ld_ready)) |=> !evt_bits[EV_LOAD]);
  a_r8_load_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> evt_bits[EV_LOAD]);
  a_r9_mask_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && mask_bits == '0) |=> !irq);
endmodule

bind spi_char_serializer spi_ser_checker #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .ld_valid     (ld_valid),
  .ld_ready     (ld_ready),
  .shift_en     (shift_en),
  .char_done    (char_done),
  .evt_clr_we   (evt_clr_we),
  .evt_clr_bits (evt_clr_bits),
  .mask_we      (mask_we),
  .mask_bits    (mask_bits),
  .evt_bits     (evt_bits),
  .irq          (irq)
);

// File: tb/spi_char_serializer_tb.sv
`timescale 1ns/1ps
module spi_char_serializer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_valid, ld_ready, ld_rev, shift_en, sdo, char_done;
  logic [15:0] ld_data;
  logic [3:0]  ld_len;
  logic        evt_clr_we, mask_we, irq;
  logic [1:0]  evt_clr_bits, mask_bits, evt_bits, mask_q;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_char_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_data(ld_data), .ld_len(ld_len), .ld_rev(ld_rev), .shift_en(shift_en),
    .sdo(sdo), .char_done(char_done), .evt_clr_we(evt_clr_we),
    .evt_clr_bits(evt_clr_bits), .mask_we(mask_we), .mask_bits(mask_bits),
    .evt_bits(evt_bits), .mask_q(mask_q), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int size_of(input logic [3:0] len);
    return (len < 3) ? 4 : int'(len) + 1;
  endfunction

  function automatic logic [15:0] line_of(input logic [15:0] d, input logic [3:0] len, input logic rev);
    logic [15:0] v = '0;
    int n = size_of(len);
    for (int k = 0; k < n; k++) v[k] = rev ? d[n-1-k] : d[k];
    return v;
  endfunction

  task automatic do_load(input logic [15:0] d, input logic [3:0] len, input logic rev);
    while (ld_ready !== 1'b1) @(negedge clk);
    ld_valid = 1'b1; ld_data = d; ld_len = len; ld_rev = rev;
    @(negedge clk);
    ld_valid = 1'b0; ld_data = 16'hFFFF;
  endtask

  task automatic shift_bits(input int n, input int base, input bit clr_last,
                            inout logic [15:0] got, inout bit early);
    for (int k = 0; k < n; k++) begin
      if (ld_ready !== 1'b0) early = 1;
      got[base+k] = sdo;
      shift_en = 1'b1;
      if (clr_last && k == n-1) begin evt_clr_we = 1'b1; evt_clr_bits = 2'b01; end
      @(negedge clk);
      shift_en = 1'b0; evt_clr_we = 1'b0; evt_clr_bits = 2'b00;
    end
  endtask

  task automatic clear_events();
    evt_clr_we = 1'b1; evt_clr_bits = 2'b11;
    @(negedge clk);
    evt_clr_we = 1'b0; evt_clr_bits = 2'b00;
  endtask

  task automatic write_mask(input logic [1:0] m);
    mask_we = 1'b1; mask_bits = m;
    @(negedge clk);
    mask_we = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 ready", ld_ready, 1);
    check("R10 sdo", sdo, 0);
    check("R10 done", char_done, 0);
    check("R10 events", evt_bits, 0);
    check("R10 mask", mask_q, 0);
    check("R10 irq", irq, 0);
  endtask

  // one character end to end; req names the order rule under test
  task automatic t_char(input string req, input logic [15:0] d, input logic [3:0] len, input logic rev);
    logic [15:0] got = '0;
    bit early = 0;
    clear_events();
    do_load(d, len, rev);
    check("R4 ready low after load", ld_ready, 0);
    check("R6 load event", evt_bits[1], 1);
    shift_bits(size_of(len), 0, 0, got, early);
    check(req, got, line_of(d, len, rev));
    check("R1 busy through all bits", early, 0);
    check("R5 done pulse", char_done, 1);
    check("R1 ready at end", ld_ready, 1);
    check("R6 done event", evt_bits[0], 1);
    @(negedge clk);
    check("R5 done one cycle", char_done, 0);
  endtask

  task automatic t_load_while_busy();
    logic [15:0] got = '0;
    bit early = 0;
    do_load(16'h00B4, 4'd7, 1'b0);
    shift_bits(3, 0, 0, got, early);
    ld_valid = 1'b1; ld_data = 16'h5A0F; ld_len = 4'd15; ld_rev = 1'b1;
    check("R4 ready low mid-char", ld_ready, 0);
    @(negedge clk);
    ld_valid = 1'b0;
    shift_bits(5, 3, 0, got, early);
    check("R4 busy load ignored", got, 16'h00B4);
    check("R4 done after original size", char_done, 1);
    @(negedge clk);
    check("R4 no queued char", ld_ready, 1);
    check("R4 line idle", sdo, 0);
  endtask

  task automatic t_idle_shift();
    bit seen = 0;
    clear_events();
    for (int k = 0; k < 4; k++) begin
      shift_en = 1'b1;
      @(negedge clk);
      if (char_done !== 1'b0 || sdo !== 1'b0) seen = 1;
    end
    shift_en = 1'b0;
    check("R5 idle shift ignored", seen, 0);
    check("R5 idle no event", evt_bits, 0);
  endtask

  task automatic t_events();
    logic [15:0] got = '0;
    bit early = 0;
    clear_events();
    check("R7 clear all", evt_bits, 0);
    do_load(16'h0009, 4'd3, 1'b0);
    shift_bits(4, 0, 0, got, early);
    check("R6 both events", evt_bits, 2'b11);
    write_mask(2'b00);
    check("R9 masked quiet", irq, 0);
    write_mask(2'b01);
    check("R9 done enabled", irq, 1);
    evt_clr_we = 1'b1; evt_clr_bits = 2'b10;
    @(negedge clk);
    evt_clr_we = 1'b0;
    check("R7 w1c selective", evt_bits, 2'b01);
    evt_clr_we = 1'b1; evt_clr_bits = 2'b00;
    @(negedge clk);
    evt_clr_we = 1'b0;
    check("R7 zero write keeps", evt_bits, 2'b01);
    write_mask(2'b10);
    check("R9 other bit masked", irq, 0);
    write_mask(2'b11);
    check("R9 irq on", irq, 1);
    clear_events();
    check("R9 irq after clear", irq, 0);
    // set and clear of the done bit collide on the last strobe
    do_load(16'h0006, 4'd3, 1'b1);
    shift_bits(4, 0, 1, got, early);
    check("R8 set wins over clear", evt_bits[0], 1);
    write_mask(2'b00);
  endtask

  initial begin
    rst_n = 1'b0; ld_valid = 0; ld_data = 0; ld_len = 0; ld_rev = 0;
    shift_en = 0; evt_clr_we = 0; evt_clr_bits = 0; mask_we = 0; mask_bits = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_char("R2 byte lsb first",       16'h00C5, 4'd7,  1'b0);
    t_char("R3 byte msb first",       16'h00C5, 4'd7,  1'b1);
    t_char("R2 13-bit upper ignored", 16'hE5A3, 4'hC,  1'b0);
    t_char("R3 13-bit mirrored",      16'hE5A3, 4'hC,  1'b1);
    t_char("R2 16-bit",               16'h9C31, 4'hF,  1'b0);
    t_char("R3 16-bit",               16'h9C31, 4'hF,  1'b1);
    t_char("R1 short code clamps",    16'hFFF6, 4'd1,  1'b1);
    t_char("R1 4-bit",                16'h000B, 4'd3,  1'b0);
    t_load_while_busy();
    t_idle_shift();
    t_events();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule